// File: doc/BRIEF.md
# Sample Decimator with Trigger Alignment

This block sits between an ADC front end and the acquisition logic. Each clock carries one multi-channel sample and a trigger flag. The block lays the four 14-bit channel codes into a 64-bit word and marks one sample in every N as valid. N comes from a ratio register that software writes. The acquisition logic stores only the valid samples, so the effective sample rate becomes the input rate divided by N.

A trigger can arrive on a sample that is thrown away. In that case the block holds it and reports it with the next sample that is kept. As a result, a trigger seen downstream always belongs to a stored sample. Triggers that arrive while one is already held are merged into a single event. A ratio of zero is treated as a ratio of one. When the ratio value changes, the decimation phase restarts, so the sample presented in the cycle of the change is kept. All outputs are registered and appear one clock after their input sample.

Top module: `sample_decimator`

## Requirements
- R1: With an effective ratio N, the first sample after reset or a ratio change is valid, followed by exactly one valid sample in every N consecutive input samples.
- R2: With ratio 1, every sample is valid and a trigger is reported with its own sample.
- R3: A ratio value of 0 gives the same output as ratio 1.
- R4: A trigger on a dropped sample is reported with the next valid sample; a trigger on a kept sample is reported with that sample. outTrig is only ever high together with outValid.
- R5: Several triggers arriving before the next valid sample produce a single reported trigger.
- R6: Once a held trigger has been reported, later valid samples carry no trigger unless a new one arrives.
- R7: Channel c (input bits [14c+13:14c]) appears in outSample bits [16c+15:16c+2]; bits [16c+1:16c] are 0.
- R8: outValid, outTrig and outSample change one clock after the input sample they belong to, never in the same cycle.
- R9: In a cycle where ratioCfg differs from its value in the previous cycle, the sample is kept, any held trigger is reported with it, and counting restarts from that sample.
- R10: While rstN is low, outValid and outTrig are 0 and outSample is 0.
- R11: Dropped samples have no effect on outSample; it holds the last valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| ratioCfg | input | 16 | Decimation ratio N from the configuration register (0 acts as 1) |
| inChannels | input | 56 | Four 14-bit ADC codes, channel c at bits [14c+13:14c] |
| inTrig | input | 1 | Trigger flag belonging to the current sample |
| outValid | output | 1 | Registered flag marking a kept sample |
| outSample | output | 64 | Registered packed sample, four 16-bit lanes |
| outTrig | output | 1 | Registered trigger, aligned to a kept sample |

## Verification
The hardest case to reach from the ports is a trigger that is still held when the ratio is rewritten. It must then come out on the restarted first sample. Reaching it takes a run at ratio 4 whose trigger falls on a dropped slot, followed in the very next cycle by a switch to ratio 5. The stimulus table also places two back-to-back triggers in one dropped interval to exercise merging. It runs a trigger that lands exactly on a kept slot, and it steps the ratio through 3, 1, 0, 2, 4 and 5 so that each change restarts the phase from a different counter value.

// File: rtl/decim_pkg.sv
package decim_pkg;
  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic keep;     // current input sample is kept
    logic trigOut;  // kept sample carries a trigger (own or held)
  } ctrl_strobes_t;
endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl #(
  parameter int RATIO_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [RATIO_BITS-1:0]  ratioCfg,
  input  logic                   inTrig,
  output decim_pkg::ctrl_strobes_t strobes
);
  localparam logic [RATIO_BITS-1:0] ONE = RATIO_BITS'(1);

  logic [RATIO_BITS-1:0] effRatio;
  logic [RATIO_BITS-1:0] ratioPrev;
  logic [RATIO_BITS-1:0] count;
  logic [RATIO_BITS-1:0] countNext;
  logic ratioChanged;
  logic keep;
  logic pending;

  // zero behaves as one
  assign effRatio     = (ratioCfg == '0) ? ONE : ratioCfg;
  assign ratioChanged = (ratioCfg != ratioPrev);
  assign keep         = ratioChanged || (count == '0);

  always_comb begin
    if (ratioChanged)
      countNext = (effRatio == ONE) ? '0 : ONE;
    else if (count >= effRatio - ONE)
      countNext = '0;
    else
      countNext = count + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      ratioPrev <= '0;
      pending   <= 1'b0;
    end else begin
      count     <= countNext;
      ratioPrev <= ratioCfg;
      pending   <= keep ? 1'b0 : (pending | inTrig);
    end
  end

  assign strobes.keep    = keep;
  assign strobes.trigOut = keep && (inTrig || pending);

  // R1: phase counter stays inside the ratio window
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ratioChanged |-> (count < effRatio));
  // R2: unity ratio keeps every sample
  p_unity_keeps_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    (effRatio == ONE) |-> keep);
  // R4: a trigger on a dropped sample is held
  p_trig_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inTrig && !keep) |=> pending);
  // R6: a held trigger is gone after a kept sample
  p_pending_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    keep |=> !pending);
endmodule

// File: rtl/decim_datapath.sv
module decim_datapath #(
  parameter int CHAN_COUNT = 4,
  parameter int ADC_BITS   = 14,
  parameter int LANE_BITS  = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  decim_pkg::ctrl_strobes_t          strobes,
  input  logic [CHAN_COUNT*ADC_BITS-1:0]    inChannels,
  output logic                              outValid,
  output logic [CHAN_COUNT*LANE_BITS-1:0]   outSample,
  output logic                              outTrig
);
  localparam int PAD_BITS = LANE_BITS - ADC_BITS;

  logic [CHAN_COUNT*LANE_BITS-1:0] packedWord;

  for (genvar c = 0; c < CHAN_COUNT; c++) begin : g_lane
    if (PAD_BITS > 0) begin : g_pad
      assign packedWord[c*LANE_BITS +: LANE_BITS] =
        {inChannels[c*ADC_BITS +: ADC_BITS], {PAD_BITS{1'b0}}};
    end else begin : g_nopad
      assign packedWord[c*LANE_BITS +: LANE_BITS] = inChannels[c*ADC_BITS +: LANE_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outTrig   <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= strobes.keep;
      outTrig  <= strobes.trigOut;
      if (strobes.keep)
        outSample <= packedWord;
    end
  end

  // R4: trigger only rides on a valid sample
  p_trig_needs_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    outTrig |-> outValid);
  // R11: dropped samples leave the output word untouched
  p_hold_on_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.keep |=> $stable(outSample));
endmodule

// File: rtl/sample_decimator.sv
module sample_decimator #(
  parameter int CHAN_COUNT = 4,
  parameter int ADC_BITS   = 14,
  parameter int LANE_BITS  = 16,
  parameter int RATIO_BITS = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [RATIO_BITS-1:0]            ratioCfg,
  input  logic [CHAN_COUNT*ADC_BITS-1:0]   inChannels,
  input  logic                             inTrig,
  output logic                             outValid,
  output logic [CHAN_COUNT*LANE_BITS-1:0]  outSample,
  output logic                             outTrig
);
  decim_pkg::ctrl_strobes_t strobes;

  decim_ctrl #(.RATIO_BITS(RATIO_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ratioCfg (ratioCfg),
    .inTrig   (inTrig),
    .strobes  (strobes)
  );

  decim_datapath #(
    .CHAN_COUNT (CHAN_COUNT),
    .ADC_BITS   (ADC_BITS),
    .LANE_BITS  (LANE_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inChannels (inChannels),
    .outValid   (outValid),
    .outSample  (outSample),
    .outTrig    (outTrig)
  );
endmodule

// File: tb/sample_decimator_test.sv
`timescale 1ns/1ps
module sample_decimator_test;
  localparam int NV = 35;
  // per-step stimulus and expected outputs (one clock later)
  // s0-15 ratio 3: R1 spacing, R4 hold, R5 merge (s7,s8), R6 no repeat (s6,s12)
  // s16-18 ratio 1: R2; s19-21 ratio 0: R3; s22-26 ratio 2
  // s27-32 ratio 4, held trigger at s32, ratio change s33: R9
  localparam int vecRatio [NV] = '{3,3,3,3,3,3,3,3,3,3,3,3,3,3,3,3,
                                   1,1,1, 0,0,0, 2,2,2,2,2, 4,4,4,4,4,4, 5,5};
  localparam int vecTrig  [NV] = '{0,1,0,0,0,0,0,1,1,0,0,0,0,0,0,1,
                                   0,1,0, 0,1,0, 0,1,0,0,0, 0,0,0,0,0,1, 0,0};
  localparam int vecValid [NV] = '{1,0,0,1,0,0,1,0,0,1,0,0,1,0,0,1,
                                   1,1,1, 1,1,1, 1,0,1,0,1, 1,0,0,0,1,0, 1,0};
  localparam int vecTrgO  [NV] = '{0,0,0,1,0,0,0,0,0,1,0,0,0,0,0,1,
                                   0,1,0, 0,1,0, 0,0,1,0,0, 0,0,0,0,0,0, 1,0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ratioCfg = 16'd3;
  logic [55:0] inChannels = '0;
  logic inTrig = 1'b0;
  logic outValid, outTrig;
  logic [63:0] outSample;
  int checks = 0;
  int failures = 0;
  logic [63:0] lastKept;

  always #2.5 clk = ~clk;

  sample_decimator uut (
    .clk(clk), .rstN(rstN), .ratioCfg(ratioCfg), .inChannels(inChannels),
    .inTrig(inTrig), .outValid(outValid), .outSample(outSample), .outTrig(outTrig)
  );

  function automatic logic [55:0] stepData(int k);
    logic [55:0] d;
    for (int c = 0; c < 4; c++)
      d[c*14 +: 14] = (k == 10) ? 14'h3fff : 14'((k*613 + c*2011 + 7));
    return d;
  endfunction

  // R7 lane layout: code in [16c+15:16c+2], zeros below
  function automatic logic [63:0] packExp(logic [55:0] d);
    logic [63:0] w = '0;
    for (int c = 0; c < 4; c++)
      w = w | (64'(d[c*14 +: 14]) << (c*16 + 2));
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 valid", 64'(outValid), 64'd0);
    chk("R10 trig", 64'(outTrig), 64'd0);
    chk("R10 sample", outSample, 64'd0);
    lastKept = '0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      rstN = 1'b1;
      ratioCfg = 16'(vecRatio[k]);
      inTrig = vecTrig[k][0];
      inChannels = stepData(k);
      @(posedge clk);
      #1;
      if (vecValid[k] != 0) lastKept = packExp(stepData(k));
      chk($sformatf("R1 valid s%0d", k), 64'(outValid), 64'(vecValid[k]));
      chk($sformatf("R4 trig s%0d", k), 64'(outTrig), 64'(vecTrgO[k]));
      chk($sformatf("%s sample s%0d", (vecValid[k] != 0) ? "R7" : "R11", k),
          outSample, lastKept);
    end

    // R10: reset in mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 mid valid", 64'(outValid), 64'd0);
    chk("R10 mid sample", outSample, 64'd0);

    // R8: no change before the clock edge, result one clock later
    @(negedge clk);
    rstN = 1'b1;
    ratioCfg = 16'd2;
    inTrig = 1'b1;
    inChannels = stepData(99);
    #1;
    chk("R8 before edge valid", 64'(outValid), 64'd0);
    chk("R8 before edge trig", 64'(outTrig), 64'd0);
    @(posedge clk);
    #1;
    chk("R8 after edge valid", 64'(outValid), 64'd1);
    chk("R8 after edge trig", 64'(outTrig), 64'd1);
    chk("R8 after edge sample", outSample, packExp(stepData(99)));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule